// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This block keeps the active-thread mask for a group of pixel threads that all run one shared instruction stream. Threads are grouped in 2x2 quads, and a group holds several quads (four quads, sixteen threads, by default). Every thread sees the same instruction; only the data differs. A control sequencer drives one command per cycle: start a new group, open a conditional (`br_if`), switch to the alternative side (`br_else`), or close the conditional (`br_endif`). Each open carries a per-thread predicate vector.

When every active thread agrees on the predicate, the group follows a single path and the other side gets an empty mask. When they disagree, the group runs the taken side under the predicate-true threads, then the alternative side under the remaining threads, then rejoins. The outer mask is saved on a small stack at each open, so conditionals can nest. When the side about to run has no live thread, the block raises a one-cycle jump request so the sequencer can skip that code. The `active_mask` output gates register writes in the execution lanes.

Top module: `simt_divergence_unit`

## Requirements
- R1: After reset, `active_mask` is all zero, `depth` is 0, and `skip_jump` and `stack_err` are 0.
- R2: `grp_start` loads `init_mask` into `active_mask`, sets `depth` to 0 and clears `stack_err` on the next cycle, and has priority over every other command in the same cycle.
- R3: An accepted `br_if` makes `active_mask` equal to the old mask ANDed with `pred` and raises `depth` by one on the next cycle; threads that were already off stay off.
- R4: When every active thread has its predicate set, `br_if` leaves `active_mask` unchanged and `skip_jump` stays 0.
- R5: When the mask after `br_if` is all zero, `skip_jump` is 1 for exactly the following cycle and is 0 again after one idle cycle.
- R6: `br_else` sets `active_mask` to the mask saved at the matching `br_if` ANDed with the inverse of that `br_if` predicate; `depth` does not change.
- R7: When the mask after `br_else` is all zero, `skip_jump` is 1 for the following cycle.
- R8: `br_endif` restores the mask saved at the matching `br_if` and lowers `depth` by one.
- R9: Conditionals nest up to DEPTH (default 4) levels; closing them restores the saved masks in last-in first-out order.
- R10: A `br_if` arriving with `depth` equal to DEPTH sets `stack_err` (sticky until the next `grp_start`) and leaves `active_mask` and `depth` unchanged.
- R11: A `br_else` or `br_endif` arriving with `depth` 0 sets `stack_err` and leaves `active_mask` and `depth` unchanged.
- R12: When several branch commands arrive together, `br_if` takes priority over `br_else`, which takes priority over `br_endif`; the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_start | input | 1 | Begin a new group with `init_mask` |
| init_mask | input | THREADS | Threads that exist in the new group |
| br_if | input | 1 | Open a conditional using `pred` |
| br_else | input | 1 | Switch to the alternative side |
| br_endif | input | 1 | Close the innermost conditional |
| pred | input | THREADS | Per-thread predicate, bit i for thread i |
| active_mask | output | THREADS | Threads allowed to write results |
| skip_jump | output | 1 | One-cycle request to jump over an empty side |
| stack_err | output | 1 | Sticky nesting overflow or underflow flag |
| depth | output | $clog2(DEPTH+1) | Number of open conditionals |

## Verification
The bench drives uniform-true, uniform-false and split predicates, and a nested conditional inside an alternative side, so a design that saves the wrong mask or inverts the predicate against the current mask instead of the saved one shows a wrong mask at `br_else` or after the inner `br_endif`. It fills the stack to its limit and then opens once more, which catches a design that wraps the stack pointer or corrupts the outermost entry, and it closes with no conditional open to catch underflow that pops garbage. It also checks that the jump request falls after one cycle, that threads missing from a partial group never come alive, and that simultaneous commands resolve in the stated order.

// File: rtl/simt_pkg.sv
// Package: shared command encoding for the divergence mask unit.
// Assumes at most one command is acted on per cycle; priority is resolved here.
package simt_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_IF    = 2'd1,
        CMD_ELSE  = 2'd2,
        CMD_ENDIF = 2'd3
    } br_cmd_e;

    // Resolve simultaneous branch strobes: open, then alternative, then close.
    function automatic br_cmd_e pick_cmd(input logic f_if, input logic f_else,
                                         input logic f_endif);
        if (f_if)
            return CMD_IF;
        else if (f_else)
            return CMD_ELSE;
        else if (f_endif)
            return CMD_ENDIF;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/simt_mask_stack.sv
// Module: simt_mask_stack
// LIFO of saved masks. Each slot keeps the outer mask at the time of an open
// and the mask for the alternative side. Assumes the caller never pushes when
// full nor pops when empty; clear empties it in one cycle.
module simt_mask_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int SPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           push,
    input  logic           pop,
    input  logic [W-1:0]   push_outer,
    input  logic [W-1:0]   push_alt,
    output logic [W-1:0]   top_outer,
    output logic [W-1:0]   top_alt,
    output logic [SPW-1:0] sp,
    output logic           full,
    output logic           empty
);

    logic [W-1:0]   outer_mem [DEPTH];
    logic [W-1:0]   alt_mem   [DEPTH];
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] top_idx;

    assign sp      = sp_q;
    assign full    = (sp_q == SPW'(DEPTH));
    assign empty   = (sp_q == '0);
    assign top_idx = empty ? '0 : sp_q - SPW'(1);

    // Stack pointer: cleared on group start, moves by one on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            sp_q <= '0;
        else if (push)
            sp_q <= sp_q + SPW'(1);
        else if (pop)
            sp_q <= sp_q - SPW'(1);
    end

    // One writer per slot; a slot loads when the pointer addresses it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                outer_mem[i] <= '0;
                alt_mem[i]   <= '0;
            end else if (push && sp_q == SPW'(i)) begin
                outer_mem[i] <= push_outer;
                alt_mem[i]   <= push_alt;
            end
        end
    end

    // Read port: select the most recently pushed slot.
    always_comb begin
        top_outer = '0;
        top_alt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (top_idx == SPW'(i)) begin
                top_outer = outer_mem[i];
                top_alt   = alt_mem[i];
            end
        end
    end

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SPW'(DEPTH));

    assert_no_push_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/simt_mask_eval.sv
// Module: simt_mask_eval
// Combinational mask arithmetic: splits the current mask by the predicate and
// reports which masks are empty. Assumes W is a multiple of 4 (whole quads);
// emptiness is reduced per quad first, then across quads.
module simt_mask_eval #(
    parameter int W = 16,
    localparam int QUADS = W / 4
) (
    input  logic [W-1:0] cur_mask,
    input  logic [W-1:0] pred,
    input  logic [W-1:0] alt_saved,
    output logic [W-1:0] taken_mask,
    output logic [W-1:0] alt_mask,
    output logic         taken_none,
    output logic         alt_saved_none
);

    logic [QUADS-1:0] quad_taken_any;
    logic [QUADS-1:0] quad_alt_any;

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        logic [3:0] qt;
        logic [3:0] qa;
        // Per-quad split of the current mask into the two sides.
        always_comb begin
            qt = cur_mask[4*q +: 4] & pred[4*q +: 4];
            qa = cur_mask[4*q +: 4] & ~pred[4*q +: 4];
        end
        assign taken_mask[4*q +: 4] = qt;
        assign alt_mask[4*q +: 4]   = qa;
        assign quad_taken_any[q]    = |qt;
        assign quad_alt_any[q]      = |alt_saved[4*q +: 4];
    end

    assign taken_none     = ~|quad_taken_any;
    assign alt_saved_none = ~|quad_alt_any;

endmodule

// File: rtl/simt_divergence_unit.sv
// Module: simt_divergence_unit (top)
// Holds the active-thread mask of one SIMD thread group and updates it on
// branch open / alternative / close commands, saving outer masks on a stack.
// Assumes one command per cycle from the sequencer; extra strobes in the same
// cycle are dropped by priority. Results appear one cycle after the command.
module simt_divergence_unit
    import simt_pkg::*;
#(
    parameter int THREADS = 16,
    parameter int DEPTH   = 4,
    localparam int SPW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_start,
    input  logic [THREADS-1:0] init_mask,
    input  logic               br_if,
    input  logic               br_else,
    input  logic               br_endif,
    input  logic [THREADS-1:0] pred,
    output logic [THREADS-1:0] active_mask,
    output logic               skip_jump,
    output logic               stack_err,
    output logic [SPW-1:0]     depth
);

    br_cmd_e            cmd;
    logic [THREADS-1:0] active_q;
    logic               skip_q;
    logic               err_q;
    logic [THREADS-1:0] taken_mask;
    logic [THREADS-1:0] alt_mask;
    logic [THREADS-1:0] top_outer;
    logic [THREADS-1:0] top_alt;
    logic               taken_none;
    logic               alt_saved_none;
    logic               st_full;
    logic               st_empty;
    logic               do_push;
    logic               do_pop;

    // Command decode with fixed priority; group start overrides everything.
    assign cmd     = grp_start ? CMD_NONE : pick_cmd(br_if, br_else, br_endif);
    assign do_push = (cmd == CMD_IF) && !st_full;
    assign do_pop  = (cmd == CMD_ENDIF) && !st_empty;

    simt_mask_eval #(.W(THREADS)) u_eval (
        .cur_mask       (active_q),
        .pred           (pred),
        .alt_saved      (top_alt),
        .taken_mask     (taken_mask),
        .alt_mask       (alt_mask),
        .taken_none     (taken_none),
        .alt_saved_none (alt_saved_none)
    );

    simt_mask_stack #(.W(THREADS), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (grp_start),
        .push       (do_push),
        .pop        (do_pop),
        .push_outer (active_q),
        .push_alt   (alt_mask),
        .top_outer  (top_outer),
        .top_alt    (top_alt),
        .sp         (depth),
        .full       (st_full),
        .empty      (st_empty)
    );

    // Mask, jump request and error flag update for the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            skip_q   <= 1'b0;
            err_q    <= 1'b0;
        end else if (grp_start) begin
            active_q <= init_mask;
            skip_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            skip_q <= 1'b0;
            unique case (cmd)
                CMD_IF: begin
                    if (st_full) begin
                        err_q <= 1'b1;
                    end else begin
                        active_q <= taken_mask;
                        skip_q   <= taken_none;
                    end
                end
                CMD_ELSE: begin
                    if (st_empty) begin
                        err_q <= 1'b1;
                    end else begin
                        active_q <= top_alt;
                        skip_q   <= alt_saved_none;
                    end
                end
                CMD_ENDIF: begin
                    if (st_empty)
                        err_q <= 1'b1;
                    else
                        active_q <= top_outer;
                end
                default: ;
            endcase
        end
    end

    assign active_mask = active_q;
    assign skip_jump   = skip_q;
    assign stack_err   = err_q;

    assert_if_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_if && !grp_start && depth != SPW'(DEPTH)) |=>
        (((active_mask & ~$past(active_mask)) == '0) && depth == $past(depth) + SPW'(1)));

    assert_skip_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        skip_jump |-> (active_mask == '0));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (br_if && !grp_start && depth == SPW'(DEPTH)) |=>
        (stack_err && $stable(active_mask) && $stable(depth)));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_start && !br_if && (br_else || br_endif) && depth == '0) |=>
        (stack_err && $stable(active_mask) && $stable(depth)));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grp_start |=> (depth == '0 && !stack_err));

    assert_endif_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_endif && !br_if && !br_else && !grp_start && depth != '0) |=>
        (depth == $past(depth) - SPW'(1)));

endmodule

// File: tb/simt_divergence_unit_test.sv
`timescale 1ns/100ps
module simt_divergence_unit_test;

    localparam int N  = 16;
    localparam int D  = 4;
    localparam int SW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grp_start = 1'b0;
    logic [N-1:0]  init_mask = '0;
    logic          br_if = 1'b0;
    logic          br_else = 1'b0;
    logic          br_endif = 1'b0;
    logic [N-1:0]  pred = '0;
    logic [N-1:0]  active_mask;
    logic          skip_jump;
    logic          stack_err;
    logic [SW-1:0] depth;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [N-1:0] m;
        int           d;
        bit           s;
        bit           e;
        string        tag;
    } exp_t;

    exp_t q[$];

    // Bench-side model of the requirements.
    logic [N-1:0] m_mask = '0;
    int           m_sp   = 0;
    bit           m_err  = 0;
    logic [N-1:0] m_out[D];
    logic [N-1:0] m_alt[D];

    always #2.5 clk = ~clk;

    simt_divergence_unit #(.THREADS(N), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .grp_start(grp_start), .init_mask(init_mask),
        .br_if(br_if), .br_else(br_else), .br_endif(br_endif), .pred(pred),
        .active_mask(active_mask), .skip_jump(skip_jump),
        .stack_err(stack_err), .depth(depth)
    );

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Driver: applies one cycle of inputs and queues the expected result.
    task automatic drive(input bit st, input logic [N-1:0] im, input bit f_if,
                         input bit f_el, input bit f_en, input logic [N-1:0] p,
                         input string tag);
        exp_t x;
        bit   s = 0;
        @(negedge clk);
        grp_start = st; init_mask = im; br_if = f_if; br_else = f_el;
        br_endif = f_en; pred = p;
        if (st) begin
            m_mask = im; m_sp = 0; m_err = 0;
        end else if (f_if) begin
            if (m_sp == D) m_err = 1;
            else begin
                m_out[m_sp] = m_mask;
                m_alt[m_sp] = m_mask & ~p;
                m_sp++;
                m_mask = m_mask & p;
                s = (m_mask == '0);
            end
        end else if (f_el) begin
            if (m_sp == 0) m_err = 1;
            else begin
                m_mask = m_alt[m_sp-1];
                s = (m_mask == '0);
            end
        end else if (f_en) begin
            if (m_sp == 0) m_err = 1;
            else begin
                m_sp--;
                m_mask = m_out[m_sp];
            end
        end
        x.m = m_mask; x.d = m_sp; x.s = s; x.e = m_err; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input string tag);
        drive(0, '0, 0, 0, 0, '0, tag);
    endtask

    // Monitor: after each edge, compare the oldest queued expectation.
    initial begin
        exp_t x;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                x = q.pop_front();
                checks++;
                if (active_mask !== x.m || int'(depth) != x.d ||
                    skip_jump !== x.s || stack_err !== x.e) begin
                    fails++;
                    $display("FAIL %s: got mask=%h depth=%0d skip=%b err=%b, expected mask=%h depth=%0d skip=%b err=%b",
                             x.tag, active_mask, depth, skip_jump, stack_err,
                             x.m, x.d, x.s, x.e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (active_mask !== '0 || depth !== '0 || skip_jump !== 1'b0 || stack_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got mask=%h depth=%0d skip=%b err=%b, expected 0000 0 0 0",
                     active_mask, depth, skip_jump, stack_err);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(1, 16'hFFFF, 0, 0, 0, '0, "R2 start full group");
        drive(0, '0, 1, 0, 0, 16'hFFFF, "R4 uniform true if");
        drive(0, '0, 0, 1, 0, '0, "R7 empty else side");
        drive(0, '0, 0, 0, 1, '0, "R8 endif restore");

        drive(0, '0, 1, 0, 0, 16'h00FF, "R3 split if");
        drive(0, '0, 0, 1, 0, '0, "R6 else uses saved mask");
        drive(0, '0, 1, 0, 0, 16'hF0F0, "R9 nested if in else");
        drive(0, '0, 0, 1, 0, '0, "R6 nested else");
        drive(0, '0, 0, 0, 1, '0, "R9 inner endif");
        drive(0, '0, 0, 0, 1, '0, "R9 outer endif");

        drive(0, '0, 1, 0, 0, 16'h0000, "R5 empty taken side");
        idle("R5 skip falls");
        drive(0, '0, 0, 1, 0, '0, "R6 else after empty taken");
        drive(0, '0, 0, 0, 1, '0, "R8 endif");

        drive(0, '0, 1, 0, 0, 16'h7FFF, "R9 level1");
        drive(0, '0, 1, 0, 0, 16'h3FFF, "R9 level2");
        drive(0, '0, 1, 0, 0, 16'h1FF1, "R9 level3");
        drive(0, '0, 1, 0, 0, 16'h0FF0, "R9 level4");
        drive(0, '0, 1, 0, 0, 16'h00F0, "R10 overflow");
        drive(0, '0, 0, 0, 1, '0, "R9 pop4");
        drive(0, '0, 0, 0, 1, '0, "R9 pop3");
        drive(0, '0, 0, 0, 1, '0, "R9 pop2");
        drive(0, '0, 0, 0, 1, '0, "R9 pop1");

        drive(1, 16'hFFFF, 0, 0, 0, '0, "R2 start clears error");
        drive(0, '0, 0, 0, 1, '0, "R11 endif underflow");
        drive(1, 16'hFFFF, 0, 0, 0, '0, "R2 restart");
        drive(0, '0, 0, 1, 0, '0, "R11 else underflow");

        drive(1, 16'h0F0F, 0, 0, 0, '0, "R2 partial group");
        drive(0, '0, 1, 0, 0, 16'hFFFF, "R3 absent threads stay off");
        drive(1, 16'hA5A5, 1, 0, 1, 16'h0000, "R12 start wins");
        drive(0, '0, 1, 0, 1, 16'h00FF, "R12 if beats endif");
        drive(0, '0, 0, 1, 1, '0, "R12 else beats endif");
        drive(0, '0, 0, 0, 1, '0, "R8 final endif");
        idle("R5 idle tail");

        @(negedge clk);
        @(negedge clk);
        finish_up();
    end

endmodule